// File: doc/BRIEF.md
# Two-Phase Transition-Signalled Latch Pipeline

This block is a chain of storage stages that move data items from a left port to a right port using two-phase bundled-data handshakes. An item is announced by one edge of a request toggle, in either direction, with its data already stable on the bus. It is acknowledged by one edge of an acknowledge toggle. No return-to-zero phase is used.

Each stage has a one-bit event latch and a data latch. The event latch holds the stage's `done` toggle. The data latch is open by default. A single XNOR of the stage's own `done` and the next stage's `done` controls both latches. When a new event is captured, the stage closes and holds its item. When the downstream stage takes the item, the stage opens again. A stage's `done` toggle serves three roles: it is the forward request to the next stage, the backward acknowledge to the previous stage, and an input to the stage's own controller.

An optional combinational step can sit on each inner link. Link `k` adds `k+1` to the data passing through it. When this step is enabled, the request on each inner link passes through a matched delay line of `MATCH_DLY` register elements. This delay must be at least as long as the logic it covers.

The model is clocked. Every latch or delay element counts as one clock cycle of propagation.

Top module: `tp_pipeline`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `in_ack`, `out_req` and every stage `done` toggle are 0. Every stage enable is 1, so all stages start open and empty.
- R2: `in_ack` changes only to take the value `in_req` held on the previous cycle. It never changes unless a new request is pending.
- R3: Items leave on the right in the order in which they were accepted on the left. No item is lost and no item is duplicated, whatever the timing of the request and acknowledge toggles.
- R4: With the link function enabled (default), each item leaves equal to its input plus N·(N−1)/2, modulo 2^W. With the defaults N=4 and W=16, the offset is 6.
- R5: In an empty pipeline with `out_ack` equal to `out_req`, `in_ack` toggles 1 cycle after an `in_req` toggle. `out_req` toggles 1+(N−1)·(MATCH_DLY+1) cycles after that `in_req` toggle, which is 10 cycles with the defaults.
- R6: A closed stage (its `done` differs from the next stage's `done`, or from `out_ack` for the last stage) keeps its data and its `done` unchanged on the next cycle. While the right side stalls, `out_data` therefore holds the oldest item.
- R7: If `out_ack` never toggles, exactly N items are accepted. A further request then gets no `in_ack` toggle.
- R8: One `out_ack` toggle on a full pipeline frees space. The pending left request is then acknowledged, and all held items drain in order.
- R9: `out_req` changes only when `out_req` and `out_ack` were equal on the previous cycle, so at most one item is offered to the right side at a time.
- R10: A stage's `done` changes only to the value that the stage's incoming request held on the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model time base; one latch or delay element per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| in_req | input | 1 | Left request toggle; one edge per item |
| in_data | input | W | Left data, stable from the `in_req` edge until `in_ack` matches |
| in_ack | output | 1 | Left acknowledge toggle (first stage `done`) |
| out_req | output | 1 | Right request toggle (last stage `done`) |
| out_data | output | W | Right data, valid while `out_req` differs from `out_ack` |
| out_ack | input | 1 | Right acknowledge toggle |

## Verification
The left acknowledge is due 1 cycle after a request edge. A result reaches the right side 1+(N−1)·(MATCH_DLY+1) cycles after the request edge when the pipeline is empty. The bench drives its inputs on falling edges and counts falling edges, so it samples each result half a cycle after the rising edge that produced it. For the stall case, the bench waits several full pipeline latencies before it checks that an acknowledge is absent and that the right-side data is held. For random timing, the bench does not predict exact cycles. It compares every right-side item against a queue of expected values built from the left-side stimulus.

// File: rtl/tp_pkg.sv
package tp_pkg;

  // Value added by inner link idx (link between stage idx and idx+1).
  function automatic int link_offset(input int idx);
    return idx + 1;
  endfunction

  // Cycles from a left request edge to the right request edge, empty pipe.
  function automatic int empty_latency(input int stages, input int dly);
    return 1 + (stages - 1) * (dly + 1);
  endfunction

endpackage

// File: rtl/tp_stage.sv
module tp_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_i,
  input  logic [W-1:0] data_i,
  input  logic         next_done_i,
  output logic         done_o,
  output logic [W-1:0] data_o,
  output logic         en_o
);
  logic         done_q;
  logic [W-1:0] data_q;

  // Single-gate controller: open while own and downstream toggles agree.
  assign en_o = ~(done_q ^ next_done_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      data_q <= '0;
    end else if (en_o) begin
      done_q <= req_i;
      data_q <= data_i;
    end
  end

  assign done_o = done_q;
  assign data_o = data_q;
endmodule

// File: rtl/tp_req_delay.sv
module tp_req_delay #(
  parameter int DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic req_o
);
  generate
    if (DLY == 0) begin : g_wire
      assign req_o = req_i;
    end else begin : g_line
      logic [DLY-1:0] tap_q;
      always_ff @(posedge clk) begin
        if (!rst_n) tap_q <= '0;
        else if (DLY == 1) tap_q[0] <= req_i;
        else tap_q <= {tap_q[DLY-2:0], req_i} & {DLY{1'b1}};
      end
      assign req_o = tap_q[DLY-1];
    end
  endgenerate
endmodule

// File: rtl/tp_link_fn.sv
module tp_link_fn #(
  parameter int W      = 16,
  parameter int IDX    = 0,
  parameter bit USE_FN = 1'b1
) (
  input  logic [W-1:0] data_i,
  output logic [W-1:0] data_o
);
  generate
    if (USE_FN) begin : g_add
      assign data_o = data_i + W'(tp_pkg::link_offset(IDX));
    end else begin : g_pass
      assign data_o = data_i;
    end
  endgenerate
endmodule

// File: rtl/tp_pipeline.sv
module tp_pipeline #(
  parameter int W         = 16,
  parameter int N         = 4,
  parameter int MATCH_DLY = 2,
  parameter bit USE_FN    = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_req,
  input  logic [W-1:0] in_data,
  output logic         in_ack,
  output logic         out_req,
  output logic [W-1:0] out_data,
  input  logic         out_ack
);
  localparam int LINK_DLY = USE_FN ? MATCH_DLY : 0;

  // Named internal events, brought out for the checker.
  logic [N-1:0]   done_vec;
  logic [N-1:0]   req_vec;
  logic [N-1:0]   en_vec;
  logic [N-1:0]   next_vec;
  logic [N*W-1:0] q_flat;
  logic [W-1:0]   q_arr [N];
  logic [W-1:0]   d_arr [N];

  assign req_vec[0] = in_req;
  assign d_arr[0]   = in_data;

  generate
    for (genvar k = 0; k < N; k++) begin : g_stage
      if (k == N - 1) begin : g_last
        assign next_vec[k] = out_ack;
      end else begin : g_inner
        assign next_vec[k] = done_vec[k+1];
      end

      tp_stage #(.W(W)) u_stage (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_vec[k]),
        .data_i      (d_arr[k]),
        .next_done_i (next_vec[k]),
        .done_o      (done_vec[k]),
        .data_o      (q_arr[k]),
        .en_o        (en_vec[k])
      );

      assign q_flat[k*W +: W] = q_arr[k];

      if (k < N - 1) begin : g_link
        tp_req_delay #(.DLY(LINK_DLY)) u_match (
          .clk   (clk),
          .rst_n (rst_n),
          .req_i (done_vec[k]),
          .req_o (req_vec[k+1])
        );
        tp_link_fn #(.W(W), .IDX(k), .USE_FN(USE_FN)) u_fn (
          .data_i (q_arr[k]),
          .data_o (d_arr[k+1])
        );
      end
    end
  endgenerate

  assign in_ack   = done_vec[0];
  assign out_req  = done_vec[N-1];
  assign out_data = q_arr[N-1];
endmodule

// File: rtl/tp_pipeline_chk.sv
module tp_pipeline_chk #(
  parameter int W = 16,
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_req,
  input logic         in_ack,
  input logic         out_req,
  input logic         out_ack,
  input logic [N-1:0] done_vec,
  input logic [N-1:0] req_vec,
  input logic [N-1:0] en_vec,
  input logic [N*W-1:0] q_flat
);
  // R1: cleared toggles on the first cycle out of reset
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (done_vec == '0 && in_ack == 1'b0 && out_req == 1'b0));

  // R2: left acknowledge only follows a pending request
  assert_ack_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(in_ack) |-> (in_ack == $past(in_req)));

  // R9: one outstanding item on the right side
  assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_req) |-> ($past(out_req) == $past(out_ack)));

  generate
    for (genvar k = 0; k < N; k++) begin : g_chk
      // R6: a closed stage holds data and event
      assert_closed_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_vec[k] |=> ($stable(q_flat[k*W +: W]) && $stable(done_vec[k])));

      // R10: event toggle copies the incoming request
      assert_done_from_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(done_vec[k]) |-> (done_vec[k] == $past(req_vec[k])));
    end
  endgenerate
endmodule

bind tp_pipeline tp_pipeline_chk #(.W(W), .N(N)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_req   (in_req),
  .in_ack   (in_ack),
  .out_req  (out_req),
  .out_ack  (out_ack),
  .done_vec (done_vec),
  .req_vec  (req_vec),
  .en_vec   (en_vec),
  .q_flat   (q_flat)
);

// File: tb/tp_pipeline_bench.sv
module tp_pipeline_bench;
  localparam int W   = 16;
  localparam int N   = 4;
  localparam int D   = 2;
  localparam int LAT = 1 + (N - 1) * (D + 1);
  localparam int OFF = N * (N - 1) / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_req = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_ack;
  logic out_req;
  logic [W-1:0] out_data;
  logic out_ack = 1'b0;

  int n_checks = 0;
  int n_fail = 0;
  logic [W-1:0] exp_q [0:1023];
  int wr_ix = 0;
  int rd_ix = 0;

  always #2 clk = ~clk;

  tp_pipeline #(.W(W), .N(N), .MATCH_DLY(D), .USE_FN(1'b1)) u_tp_pipeline (
    .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_data(in_data),
    .in_ack(in_ack), .out_req(out_req), .out_data(out_data), .out_ack(out_ack)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  task automatic drive_item(input logic [W-1:0] v);
    @(negedge clk);
    in_data = v;
    in_req  = ~in_req;
    exp_q[wr_ix] = v + W'(OFF);
    wr_ix++;
  endtask

  task automatic wait_ack(input int limit, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (in_ack == in_req) begin ok = 1'b1; break; end
    end
  endtask

  task automatic producer(input int count, input int max_gap);
    bit ok;
    for (int i = 0; i < count; i++) begin
      repeat ($urandom_range(max_gap, 0)) @(negedge clk);
      drive_item(W'($urandom));
      wait_ack(200, ok);
      check(ok, "R3 left accept", int'(ok), 1);
    end
  endtask

  task automatic consumer(input int count, input int max_gap);
    int got = 0;
    int idle = 0;
    while (got < count && idle < 400) begin
      @(negedge clk);
      if (out_req != out_ack) begin
        // R3 order and R4 transform
        check(out_data == exp_q[rd_ix], "R3/R4 item", int'(out_data), int'(exp_q[rd_ix]));
        rd_ix++;
        got++;
        idle = 0;
        repeat ($urandom_range(max_gap, 0)) @(negedge clk);
        out_ack = ~out_ack;
      end else idle++;
    end
    check(got == count, "R3 item count", got, count);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(in_ack == 1'b0 && out_req == 1'b0, "R1 reset", int'({in_ack, out_req}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ack == 1'b0 && out_req == 1'b0, "R1 after reset", int'({in_ack, out_req}), 0);
  endtask

  task automatic t_latency();
    int k = 0;
    int ack_at = -1;
    logic r0 = out_req;
    drive_item(16'h1234);
    while (out_req == r0 && k < 100) begin
      @(negedge clk);
      k++;
      if (ack_at < 0 && in_ack == in_req) ack_at = k;
    end
    check(ack_at == 1, "R5 left ack cycles", ack_at, 1);
    check(k == LAT, "R5 right req cycles", k, LAT);
    check(out_data == 16'h1234 + W'(OFF), "R4 offset", int'(out_data), int'(16'h1234 + OFF));
    rd_ix++;
    out_ack = ~out_ack;
    @(negedge clk);
  endtask

  task automatic t_stream(input int count, input int pgap, input int cgap);
    fork
      producer(count, pgap);
      consumer(count, cgap);
    join
  endtask

  task automatic t_fill();
    bit ok;
    logic [W-1:0] head;
    for (int i = 0; i < N; i++) begin
      drive_item(W'(16'hA000 + i));
      wait_ack(100, ok);
      check(ok, "R7 accept while space", i, N);
    end
    head = exp_q[rd_ix];
    drive_item(16'hBEEF);
    repeat (4 * LAT) @(negedge clk);
    check(in_ack != in_req, "R7 no ack when full", int'(in_ack), int'(~in_req));
    check(out_data == head, "R6 held output", int'(out_data), int'(head));
    check(out_req != out_ack, "R6 item offered", int'(out_req), int'(~out_ack));
    // R8: one right acknowledge frees a slot
    check(out_data == exp_q[rd_ix], "R8 head item", int'(out_data), int'(exp_q[rd_ix]));
    rd_ix++;
    out_ack = ~out_ack;
    wait_ack(LAT + 8, ok);
    check(ok, "R8 pending accepted", int'(ok), 1);
    consumer(N, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_stream(20, 0, 0);
    t_stream(40, 6, 6);
    t_stream(30, 0, 12);
    t_fill();
    t_stream(20, 3, 1);
    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule